// File: doc/BRIEF.md
# Operand Stack with Copy and Rotate

This block is the operand stack of a stack-machine core. Arithmetic units take their operands from the top of the stack and write their result back onto it, so the two uppermost entries are always presented on output ports for the ALU. Return addresses live on a separate stack, so calls never interleave addresses with operands here.

Besides ordinary push and pop, the stack supports two operations that are not last-in first-out. Copy duplicates the entry at a given depth onto the top and leaves the original where it was. Rotate lifts the entry at a given depth to the top and closes the gap in one cycle. Commands that would overfill or read past the live entries raise a one-cycle error flag and change nothing.

Top module: `operand_stack`

## Requirements
- R1: After reset the entry count is 0 and both error flags are low.
- R2: Push (cmd 1) places wrData on top and moves every entry one position deeper. The count rises by one and the old top becomes the next-of-stack.
- R3: Pop (cmd 2) removes the top entry. The count falls by one and the old next-of-stack becomes the top.
- R4: Copy (cmd 3) with depth d, where d is below the count, pushes a duplicate of the entry at depth d and raises the count by one. Depth 0 means the top entry.
- R5: Copy with depth 0 duplicates the top entry, so top and next-of-stack become equal.
- R6: Rotate (cmd 4) with depth d, where 0 < d < count, moves the entry at depth d to the top. The entries above it each move one deeper, entries below d keep their places, and the count is unchanged.
- R7: Rotate with depth 0 on a non-empty stack changes neither the contents nor the count.
- R8: Push or copy while the count equals the capacity sets the overflow flag for one cycle and leaves the contents and count unchanged.
- R9: Pop on an empty stack, or copy or rotate with depth at or beyond the count, sets the underflow flag for one cycle and leaves the contents and count unchanged.
- R10: The top and next-of-stack outputs follow the stored entries with no added register stage. Both error flags are low in the cycle after any legal command or a no-op (cmd 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | 0 no-op, 1 push, 2 pop, 3 copy, 4 rotate |
| depth | input | IDXW | Depth index for copy and rotate; 0 is the top |
| wrData | input | WIDTH | Value to push |
| topData | output | WIDTH | Entry at depth 0 |
| nextData | output | WIDTH | Entry at depth 1 |
| depthCount | output | CNTW | Number of live entries |
| ovfErr | output | 1 | Overflow on the previous command |
| unfErr | output | 1 | Underflow on the previous command |

## Verification
A corrupted count shows in the cycle after the faulty command, both on depthCount and in the next command's legality. A count that drifts makes a later push wrongly overflow or a later pop wrongly underflow. A wrong shift across the entries stays hidden until the disturbed slot is brought up, so the bench follows each copy and rotate with pops or deep rotates that expose every moved entry. The scoreboard compares top, next and count after every command, so a fault is reported within the same cycle it becomes visible.

// File: rtl/opstack_pkg.sv
package opstack_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PUSH = 3'd1,
    CMD_POP  = 3'd2,
    CMD_COPY = 3'd3,
    CMD_ROT  = 3'd4
  } stkCmd_e;

  typedef struct packed {
    logic pushIn;   // shift deeper, load wrData on top
    logic pushSel;  // shift deeper, load selected entry on top
    logic popOut;   // shift toward top
    logic rotSel;   // partial shift, selected entry to top
  } stkStrobe_t;
endpackage

// File: rtl/opstack_ctrl.sv
module opstack_ctrl
  import opstack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [2:0]      cmd,
  input  logic [IDXW-1:0] depth,
  output stkStrobe_t      strobe,
  output logic [CNTW-1:0] count,
  output logic            ovfErr,
  output logic            unfErr
);
  localparam logic [CNTW-1:0] FULLCNT = CNTW'(DEPTH);

  stkCmd_e cmdE;
  logic    isFull, isEmpty, depthOk, ovfNow, unfNow;

  always_comb begin
    cmdE    = stkCmd_e'(cmd);
    isFull  = (count == FULLCNT);
    isEmpty = (count == '0);
    depthOk = (CNTW'(depth) < count);
    strobe  = '0;
    ovfNow  = 1'b0;
    unfNow  = 1'b0;
    case (cmdE)
      CMD_PUSH: if (isFull) ovfNow = 1'b1; else strobe.pushIn = 1'b1;
      CMD_POP:  if (isEmpty) unfNow = 1'b1; else strobe.popOut = 1'b1;
      CMD_COPY: begin
        if (isFull)        ovfNow = 1'b1;
        else if (!depthOk) unfNow = 1'b1;
        else               strobe.pushSel = 1'b1;
      end
      CMD_ROT: begin
        if (!depthOk)           unfNow = 1'b1;
        else if (depth != '0)   strobe.rotSel = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= '0;
      ovfErr <= 1'b0;
      unfErr <= 1'b0;
    end else begin
      ovfErr <= ovfNow;
      unfErr <= unfNow;
      if (strobe.pushIn || strobe.pushSel) count <= count + 1'b1;
      else if (strobe.popOut)              count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/opstack_data.sv
module opstack_data
  import opstack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stkStrobe_t       strobe,
  input  logic [IDXW-1:0]  depth,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] topData,
  output logic [WIDTH-1:0] nextData
);
  logic [WIDTH-1:0] entry [DEPTH];
  logic [WIDTH-1:0] selVal;

  assign selVal   = entry[depth];
  assign topData  = entry[0];
  assign nextData = entry[1];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [WIDTH-1:0] deeperVal, shallowerVal;
    if (i == 0) begin : g_top
      assign shallowerVal = strobe.pushIn ? wrData : selVal;
    end else begin : g_mid
      assign shallowerVal = entry[i-1];
    end
    if (i == DEPTH - 1) begin : g_bot
      assign deeperVal = '0;
    end else begin : g_up
      assign deeperVal = entry[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entry[i] <= '0;
      end else if (strobe.pushIn || strobe.pushSel) begin
        entry[i] <= shallowerVal;
      end else if (strobe.popOut) begin
        entry[i] <= deeperVal;
      end else if (strobe.rotSel && (depth >= IDXW'(i))) begin
        entry[i] <= shallowerVal;
      end
    end
  end
endmodule

// File: rtl/operand_stack.sv
module operand_stack
  import opstack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmd,
  input  logic [IDXW-1:0]  depth,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] topData,
  output logic [WIDTH-1:0] nextData,
  output logic [CNTW-1:0]  depthCount,
  output logic             ovfErr,
  output logic             unfErr
);
  stkStrobe_t strobe;

  opstack_ctrl #(.DEPTH(DEPTH), .IDXW(IDXW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .depth(depth),
    .strobe(strobe), .count(depthCount), .ovfErr(ovfErr), .unfErr(unfErr)
  );

  opstack_data #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDXW(IDXW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .depth(depth),
    .wrData(wrData), .topData(topData), .nextData(nextData)
  );
endmodule

// File: rtl/opstack_chk.sv
module opstack_chk
  import opstack_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  parameter int IDXW  = $clog2(DEPTH),
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cmd,
  input logic [IDXW-1:0]  depth,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] topData,
  input logic [WIDTH-1:0] nextData,
  input logic [CNTW-1:0]  depthCount,
  input logic             ovfErr,
  input logic             unfErr
);
  localparam logic [CNTW-1:0] FULLCNT = CNTW'(DEPTH);

  // R2
  a_r2_push_grow: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_PUSH && depthCount != FULLCNT) |=>
      (topData == $past(wrData) && depthCount == $past(depthCount) + 1'b1));
  // R3
  a_r3_pop_shrink: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_POP && depthCount != '0) |=>
      (depthCount == $past(depthCount) - 1'b1 && topData == $past(nextData)));
  // R4
  a_r4_copy_grow: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_COPY && depthCount != FULLCNT && CNTW'(depth) < depthCount) |=>
      (depthCount == $past(depthCount) + 1'b1));
  // R6
  a_r6_rot_swap1: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ROT && depth == IDXW'(1) && depthCount > CNTW'(1)) |=>
      (topData == $past(nextData) && nextData == $past(topData) && $stable(depthCount)));
  // R7
  a_r7_rot_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_ROT && depth == '0 && depthCount != '0) |=>
      ($stable(topData) && $stable(nextData) && $stable(depthCount)));
  // R8
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd == CMD_PUSH || cmd == CMD_COPY) && depthCount == FULLCNT) |=>
      (ovfErr && $stable(depthCount) && $stable(topData)));
  // R9
  a_r9_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_POP && depthCount == '0) |=> (unfErr && depthCount == '0));
  // R10
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfErr && unfErr));
  // R10
  a_r10_nop_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_NOP) |=> (!ovfErr && !unfErr && $stable(depthCount)));
endmodule

bind operand_stack opstack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDXW(IDXW), .CNTW(CNTW)) u_chk (.*);

// File: tb/sim_operand_stack.sv
module sim_operand_stack;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;
  localparam int IDXW  = 4;
  localparam int CNTW  = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       cmd = 3'd0;
  logic [IDXW-1:0]  depth = '0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] topData, nextData;
  logic [CNTW-1:0]  depthCount;
  logic             ovfErr, unfErr;

  always #4 clk = ~clk;  // 125 MHz

  operand_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rstN(rstN), .cmd(cmd), .depth(depth), .wrData(wrData),
    .topData(topData), .nextData(nextData), .depthCount(depthCount),
    .ovfErr(ovfErr), .unfErr(unfErr)
  );

  typedef struct {
    logic [WIDTH-1:0] top;
    logic [WIDTH-1:0] nxt;
    int               cnt;
    logic             ovf;
    logic             unf;
    string            tag;
  } expItem_t;

  expItem_t         expQ[$];
  logic [WIDTH-1:0] model [DEPTH];
  int               mCnt = 0;
  int               tests = 0;
  int               fails = 0;
  bit               done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: compares each result one negedge after the edge that made it
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(e.tag, "count", int'(depthCount), e.cnt);
      check(e.tag, "ovf", int'(ovfErr), int'(e.ovf));
      check(e.tag, "unf", int'(unfErr), int'(e.unf));
      if (e.cnt >= 1) check(e.tag, "top", int'(topData), int'(e.top));
      if (e.cnt >= 2) check(e.tag, "next", int'(nextData), int'(e.nxt));
    end
  end

  // driver: applies a command, updates the model, queues the expectation
  task automatic doOp(input int c, input int d, input int v, input string tag);
    logic ovf, unf;
    logic [WIDTH-1:0] sv;
    ovf = 0; unf = 0;
    @(negedge clk);
    cmd = 3'(c); depth = IDXW'(d); wrData = WIDTH'(v);
    case (c)
      1: if (mCnt == DEPTH) ovf = 1;
         else begin
           for (int i = DEPTH - 1; i > 0; i--) model[i] = model[i-1];
           model[0] = WIDTH'(v); mCnt++;
         end
      2: if (mCnt == 0) unf = 1;
         else begin
           for (int i = 0; i < DEPTH - 1; i++) model[i] = model[i+1];
           model[DEPTH-1] = '0; mCnt--;
         end
      3: if (mCnt == DEPTH) ovf = 1;
         else if (d >= mCnt) unf = 1;
         else begin
           sv = model[d];
           for (int i = DEPTH - 1; i > 0; i--) model[i] = model[i-1];
           model[0] = sv; mCnt++;
         end
      4: if (d >= mCnt) unf = 1;
         else begin
           sv = model[d];
           for (int i = d; i > 0; i--) model[i] = model[i-1];
           model[0] = sv;
         end
      default: ;
    endcase
    @(posedge clk);
    #1;
    expQ.push_back('{model[0], model[1], mCnt, ovf, unf, tag});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "count", int'(depthCount), 0);
    check("R1", "flags", int'({ovfErr, unfErr}), 0);
    rstN = 1'b1;

    doOp(2, 0, 0, "R9 pop empty");
    doOp(3, 0, 0, "R9 copy empty");
    doOp(4, 0, 0, "R9 rot empty");
    doOp(1, 0, 11, "R2 push");
    doOp(1, 0, 22, "R2 push");
    doOp(1, 0, 33, "R2 push");
    doOp(0, 0, 0, "R10 nop");
    doOp(3, 2, 0, "R4 copy d2");
    doOp(3, 0, 0, "R5 copy d0");
    doOp(4, 3, 0, "R6 rot d3");
    doOp(4, 1, 0, "R6 rot d1");
    doOp(4, 0, 0, "R7 rot d0");
    doOp(4, 5, 0, "R9 rot past count");
    doOp(3, 7, 0, "R9 copy past count");
    doOp(2, 0, 0, "R3 pop");
    doOp(2, 0, 0, "R3 pop");
    for (int k = 0; mCnt < DEPTH; k++) doOp(1, 0, 100 + k, "R2 fill");
    doOp(1, 0, 999, "R8 push full");
    doOp(3, 4, 0, "R8 copy full");
    doOp(4, 15, 0, "R6 rot deepest");
    doOp(4, 8, 0, "R6 rot mid");
    while (mCnt > 0) doOp(2, 0, 0, "R3 drain");
    doOp(2, 0, 0, "R9 pop after drain");
    doOp(0, 0, 0, "R10 nop clear");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule